// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a simple word-wide register bus inside an SoC. Software programs a control word, a load value and a compare value. It can read a live counter value at any time. The counter steps down by one on each tick of a selected clock enable. When it reaches zero it either reloads from the load value or wraps to all ones. A reload can also happen when counting is switched on, and a write to the load value can take effect at once.

When the counter takes the compare value, a sticky status flag is set. Together with an enable bit, that flag drives a level interrupt. Three low-power mode inputs can freeze counting unless the matching keep-running bit is set. A self-clearing soft-reset bit returns the timer to a clean state within a fixed number of cycles. The clock and low-power settings survive the soft reset.

Top module: `ivt_timer`

## Requirements
- R1: After the synchronous reset `rst`, every register reads 0 and `irq` is 0.
- R2: With control bit 0 (run) set, the counter drops by 1 on each cycle in which the tick input picked by control bits 25:24 is high: 1 picks `tick_bus`, 2 picks `tick_hf`, 3 picks `tick_lf`. Value 0 stops counting. The other tick inputs have no effect. With run clear, the counter holds its value.
- R3: With control bit 3 clear, a tick at a count of 0 makes the counter 0xFFFFFFFF.
- R4: With control bit 3 set, a tick at a count of 0 loads the counter from the load register. A load value of 0 keeps the counter at 0.
- R5: With control bit 1 set, a 0-to-1 change of the run bit loads the counter from the load register one cycle after the control write. With bit 1 clear, counting resumes from the held value.
- R6: With control bit 17 set, a load-register write also sets the counter in the same cycle. With bit 17 clear, the counter is unchanged by the write.
- R7: Status bit 0 is set in the cycle the counter takes the compare value, whether by a tick, a reload or a load. It stays set when 0 is written to it. Writing 1 to status bit 0 clears it, and a new match in the same cycle wins over the clear.
- R8: `irq` is high exactly while status bit 0 and control bit 2 are both set.
- R9: Ticks are ignored while `dbg_mode` is high and control bit 18 is clear. The same holds for `wait_mode` with control bit 19 and for `stop_mode` with control bit 21.
- R10: Writing control with bit 16 set starts a soft reset. Bit 16 reads 1 for SRST_CYCLES cycles after the write, then reads 0. Control keeps only bits 25:24, 18, 19 and 21 as written. The load, compare, counter and status registers become 0. Bus writes during the soft reset are ignored.
- R11: The registers sit at word indices 0 (control), 1 (status), 2 (load), 3 (compare) and 4 (counter, read-only). A write to index 4 has no effect, and other indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_word | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| tick_bus | input | 1 | Bus-clock tick enable |
| tick_hf | input | 1 | High-frequency tick enable |
| tick_lf | input | 1 | Low-frequency tick enable |
| dbg_mode | input | 1 | Debug mode active |
| wait_mode | input | 1 | Wait mode active |
| stop_mode | input | 1 | Stop mode active |
| irq | output | 1 | Compare interrupt, level |

## Verification
The bench sweeps every pairing of clock-source code and tick input. A mis-decoded selector would count on the wrong enable or count with the source off. It walks the counter through zero in both wrap and reload modes, for several small load values including 0. An off-by-one there would show as a skipped or repeated count, or a wrap where a reload was due. It probes the compare flag against writes of 0 and 1 and against a match caused by an immediate load, which exposes a flag that is not sticky or not write-one-to-clear. It also covers the edge-triggered reload on enable, the three low-power freezes, and the exact length of the soft-reset window. A design that got the soft reset wrong would lose the kept bits, clear the busy bit early, or accept writes while still resetting.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BUS_W  = 32;
    localparam int WORD_W = 3;
    localparam int N_SRC  = 3;
    localparam int N_LP   = 3;

    localparam logic [WORD_W-1:0] W_CTRL = 3'd0;
    localparam logic [WORD_W-1:0] W_STAT = 3'd1;
    localparam logic [WORD_W-1:0] W_LOAD = 3'd2;
    localparam logic [WORD_W-1:0] W_CMP  = 3'd3;
    localparam logic [WORD_W-1:0] W_CNT  = 3'd4;

    localparam int B_RUN   = 0;
    localparam int B_RLDEN = 1;
    localparam int B_OCIE  = 2;
    localparam int B_RLDZ  = 3;
    localparam int B_SRST  = 16;
    localparam int B_IMM   = 17;
    localparam int B_KDBG  = 18;
    localparam int B_KWAIT = 19;
    localparam int B_KSTOP = 21;
    localparam int B_SRC   = 24;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_BUS = 2'd1,
        SRC_HF  = 2'd2,
        SRC_LF  = 2'd3
    } clk_src_e;

    typedef struct packed {
        clk_src_e src;
        logic     keep_stop;
        logic     keep_wait;
        logic     keep_dbg;
        logic     imm_load;
        logic     reload_zero;
        logic     ocie;
        logic     reload_en;
        logic     run;
    } ctrl_t;

    function automatic logic [BUS_W-1:0] ctrl_to_word(ctrl_t c, logic busy);
        logic [BUS_W-1:0] w;
        w = '0;
        w[B_RUN]            = c.run;
        w[B_RLDEN]          = c.reload_en;
        w[B_OCIE]           = c.ocie;
        w[B_RLDZ]           = c.reload_zero;
        w[B_SRST]           = busy;
        w[B_IMM]            = c.imm_load;
        w[B_KDBG]           = c.keep_dbg;
        w[B_KWAIT]          = c.keep_wait;
        w[B_KSTOP]          = c.keep_stop;
        w[B_SRC+1:B_SRC]    = c.src;
        return w;
    endfunction

endpackage

// File: rtl/ivt_tick_sel.sv
module ivt_tick_sel
    import ivt_pkg::*;
(
    input  logic             run_i,
    input  clk_src_e         src_i,
    input  logic [N_SRC-1:0] ticks_i,
    input  logic [N_LP-1:0]  lp_mode_i,
    input  logic [N_LP-1:0]  lp_keep_i,
    output logic             tick_o
);
    logic [N_LP-1:0] lp_ok;
    logic            src_tick;

    genvar g;
    generate
        for (g = 0; g < N_LP; g++) begin : g_lp
            assign lp_ok[g] = !lp_mode_i[g] || lp_keep_i[g];
        end
    endgenerate

    always_comb begin
        case (src_i)
            SRC_BUS: src_tick = ticks_i[0];
            SRC_HF:  src_tick = ticks_i[1];
            SRC_LF:  src_tick = ticks_i[2];
            default: src_tick = 1'b0;
        endcase
    end

    assign tick_o = run_i && src_tick && (&lp_ok);
endmodule

// File: rtl/ivt_srst.sv
module ivt_srst #(
    parameter int SRST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int SW = $clog2(SRST_CYCLES + 1);
    localparam logic [SW-1:0] LEN = SW'(SRST_CYCLES);

    logic [SW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= LEN;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy_o = (left_q != '0);

    // R10
    srst_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             reload_en_i,
    input  logic             reload_zero_i,
    input  logic [CNT_W-1:0] lr_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             imm_ld_i,
    input  logic [CNT_W-1:0] imm_data_i,
    input  logic             srst_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             run_q;
    logic             upd;
    logic             en_edge;

    assign en_edge = run_i && !run_q && reload_en_i;

    always_comb begin
        cnt_nxt = cnt_q;
        upd     = 1'b0;
        if (imm_ld_i) begin
            cnt_nxt = imm_data_i;
            upd     = 1'b1;
        end else if (en_edge) begin
            cnt_nxt = lr_i;
            upd     = 1'b1;
        end else if (tick_i) begin
            upd = 1'b1;
            if (cnt_q == '0) begin
                cnt_nxt = reload_zero_i ? lr_i : '1;
            end else begin
                cnt_nxt = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst_i) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            run_q <= run_i;
        end
    end

    assign cnt_o   = cnt_q;
    assign match_o = upd && !srst_i && (cnt_nxt == cmp_i);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !imm_ld_i && !srst_i && !(run_i && reload_en_i)) |=> $stable(cnt_q));

    // R2
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !imm_ld_i && !srst_i && !en_edge && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !imm_ld_i && !srst_i && !en_edge && cnt_q == '0 && !reload_zero_i)
        |=> (cnt_q == '1));

    // R4
    cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !imm_ld_i && !srst_i && !en_edge && cnt_q == '0 && reload_zero_i)
        |=> (cnt_q == $past(lr_i)));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              match_i,
    input  logic              busy_i,
    output logic              run_o,
    output logic              reload_en_o,
    output logic              reload_zero_o,
    output logic              ocie_o,
    output clk_src_e          src_o,
    output logic [N_LP-1:0]   keep_o,
    output logic              imm_ld_o,
    output logic              flag_o,
    output logic [CNT_W-1:0]  lr_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              srst_start_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] lr_q, cmp_q;
    logic             flag_q;
    logic             wr_ok;
    logic             wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic             srst_start;
    logic             flag_clr;

    assign wr_ok      = bus_wr && !busy_i;
    assign wr_ctrl    = wr_ok && (bus_word == W_CTRL);
    assign wr_stat    = wr_ok && (bus_word == W_STAT);
    assign wr_load    = wr_ok && (bus_word == W_LOAD);
    assign wr_cmp     = wr_ok && (bus_word == W_CMP);
    assign srst_start = wr_ctrl && bus_wdata[B_SRST];
    assign flag_clr   = wr_stat && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (srst_start) begin
            ctrl_q           <= '0;
            ctrl_q.src       <= clk_src_e'(bus_wdata[B_SRC+1:B_SRC]);
            ctrl_q.keep_dbg  <= bus_wdata[B_KDBG];
            ctrl_q.keep_wait <= bus_wdata[B_KWAIT];
            ctrl_q.keep_stop <= bus_wdata[B_KSTOP];
        end else if (wr_ctrl) begin
            ctrl_q.run         <= bus_wdata[B_RUN];
            ctrl_q.reload_en   <= bus_wdata[B_RLDEN];
            ctrl_q.ocie        <= bus_wdata[B_OCIE];
            ctrl_q.reload_zero <= bus_wdata[B_RLDZ];
            ctrl_q.imm_load    <= bus_wdata[B_IMM];
            ctrl_q.keep_dbg    <= bus_wdata[B_KDBG];
            ctrl_q.keep_wait   <= bus_wdata[B_KWAIT];
            ctrl_q.keep_stop   <= bus_wdata[B_KSTOP];
            ctrl_q.src         <= clk_src_e'(bus_wdata[B_SRC+1:B_SRC]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst_start) begin
            lr_q  <= '0;
            cmp_q <= '0;
        end else begin
            if (wr_load) lr_q  <= bus_wdata[CNT_W-1:0];
            if (wr_cmp)  cmp_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || srst_start) begin
            flag_q <= 1'b0;
        end else if (match_i) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_word)
            W_CTRL:  bus_rdata = ctrl_to_word(ctrl_q, busy_i);
            W_STAT:  bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
            W_LOAD:  bus_rdata = BUS_W'(lr_q);
            W_CMP:   bus_rdata = BUS_W'(cmp_q);
            W_CNT:   bus_rdata = BUS_W'(cnt_i);
            default: bus_rdata = '0;
        endcase
    end

    assign run_o         = ctrl_q.run;
    assign reload_en_o   = ctrl_q.reload_en;
    assign reload_zero_o = ctrl_q.reload_zero;
    assign ocie_o        = ctrl_q.ocie;
    assign src_o         = ctrl_q.src;
    assign keep_o        = {ctrl_q.keep_stop, ctrl_q.keep_wait, ctrl_q.keep_dbg};
    assign imm_ld_o      = wr_load && ctrl_q.imm_load;
    assign flag_o        = flag_q;
    assign lr_o          = lr_q;
    assign cmp_o         = cmp_q;
    assign srst_start_o  = srst_start;

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !srst_start && !flag_clr) |=> flag_q);

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (match_i && !srst_start) |=> flag_q);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> ($stable(lr_q) && $stable(cmp_q)));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SRST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_word,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tick_bus,
    input  logic              tick_hf,
    input  logic              tick_lf,
    input  logic              dbg_mode,
    input  logic              wait_mode,
    input  logic              stop_mode,
    output logic              irq
);
    logic             run, reload_en, reload_zero, ocie;
    clk_src_e         src;
    logic [N_LP-1:0]  keep;
    logic             imm_ld, flag, srst_start, busy, tick, match;
    logic [CNT_W-1:0] lr, cmp, cnt;

    ivt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .match_i(match), .busy_i(busy),
        .run_o(run), .reload_en_o(reload_en), .reload_zero_o(reload_zero), .ocie_o(ocie),
        .src_o(src), .keep_o(keep), .imm_ld_o(imm_ld), .flag_o(flag),
        .lr_o(lr), .cmp_o(cmp), .srst_start_o(srst_start)
    );

    ivt_srst #(.SRST_CYCLES(SRST_CYCLES)) srst_i (
        .clk(clk), .rst(rst), .start_i(srst_start), .busy_o(busy)
    );

    ivt_tick_sel tsel_i (
        .run_i(run), .src_i(src),
        .ticks_i({tick_lf, tick_hf, tick_bus}),
        .lp_mode_i({stop_mode, wait_mode, dbg_mode}),
        .lp_keep_i(keep),
        .tick_o(tick)
    );

    ivt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .tick_i(tick), .run_i(run),
        .reload_en_i(reload_en), .reload_zero_i(reload_zero),
        .lr_i(lr), .cmp_i(cmp), .imm_ld_i(imm_ld),
        .imm_data_i(bus_wdata[CNT_W-1:0]), .srst_i(srst_start),
        .cnt_o(cnt), .match_o(match)
    );

    assign irq = flag && ocie;
endmodule

// File: tb/ivt_timer_tb_top.sv
`timescale 1ns/10ps
module ivt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_word = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [2:0]  ticks = 3'b000;
    logic [2:0]  modes = 3'b000;
    logic        irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    localparam logic [31:0] RUN = 32'h1, RLDEN = 32'h2, OCIE = 32'h4, RLDZ = 32'h8;
    localparam logic [31:0] SRST = 32'h1_0000, IMM = 32'h2_0000;

    always #2 clk = ~clk;

    ivt_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_bus(ticks[0]), .tick_hf(ticks[1]), .tick_lf(ticks[2]),
        .dbg_mode(modes[0]), .wait_mode(modes[1]), .stop_mode(modes[2]),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] w, input logic [31:0] exp, input string tag);
        bus_word = w;
        #0.1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick(input int t);
        @(negedge clk);
        ticks[t] = 1'b1;
        @(negedge clk);
        ticks = 3'b000;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int w = 0; w < 5; w++) rd(3'(w), 32'h0, "R1 register after reset");
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R11 map, read-only counter, unmapped word
        wr(3'd3, 32'h55);
        rd(3'd3, 32'h55, "R11 compare readback");
        wr(3'd4, 32'h1234);
        rd(3'd4, 32'h0, "R11 counter write ignored");
        rd(3'd5, 32'h0, "R11 unmapped word");

        // R6 immediate overwrite off / on
        wr(3'd2, 32'd10);
        rd(3'd4, 32'h0, "R6 load without overwrite");
        wr(3'd0, IMM);
        wr(3'd2, 32'd20);
        rd(3'd4, 32'd20, "R6 load with overwrite");

        // R2 sweep of source code against tick input
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 3; t++) begin
                wr(3'd0, RUN | IMM | (32'(s) << 24));
                wr(3'd2, 32'd100);
                repeat (3) tick(t);
                rd(3'd4, (s == t + 1) ? 32'd97 : 32'd100, "R2 source select");
            end
        end

        // R3 wrap without reload
        wr(3'd0, RUN | IMM | (32'd1 << 24));
        wr(3'd2, 32'd2);
        exp = 32'd2;
        for (int i = 0; i < 4; i++) begin
            tick(0);
            exp = exp - 32'd1;
            rd(3'd4, exp, "R3 count through zero");
        end

        // R4 reload sweep over small load values
        for (int l = 0; l < 4; l++) begin
            wr(3'd0, RUN | RLDZ | IMM | (32'd1 << 24));
            wr(3'd2, 32'(l));
            exp = 32'(l);
            for (int i = 0; i < 2 * l + 2; i++) begin
                tick(0);
                exp = (exp == 0) ? 32'(l) : exp - 32'd1;
                rd(3'd4, exp, "R4 reload at zero");
            end
        end

        // R7 / R8 compare flag and interrupt
        wr(3'd2, 32'd5);
        rd(3'd1, 32'h0, "R7 no match yet");
        wr(3'd3, 32'd4);
        tick(0);
        rd(3'd4, 32'd4, "R2 count to compare");
        rd(3'd1, 32'h1, "R7 flag on match");
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd1, 32'h1, "R7 write 0 keeps flag");
        wr(3'd0, RUN | RLDZ | IMM | OCIE | (32'd1 << 24));
        chk("R8 irq enabled", {31'b0, irq}, 32'h1);
        tick(0);
        rd(3'd1, 32'h1, "R7 flag sticky past match");
        wr(3'd1, 32'h1);
        rd(3'd1, 32'h0, "R7 write 1 clears");
        chk("R8 irq after clear", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'd4);
        rd(3'd1, 32'h1, "R7 match by load");
        wr(3'd1, 32'h1);

        // R5 reload on enable edge
        wr(3'd0, RLDEN | (32'd1 << 24));
        wr(3'd2, 32'd50);
        rd(3'd4, 32'd4, "R6 load ignored without overwrite");
        wr(3'd0, RUN | RLDEN | (32'd1 << 24));
        @(negedge clk);
        rd(3'd4, 32'd50, "R5 reload on enable");
        wr(3'd0, 32'd1 << 24);
        tick(0);
        rd(3'd4, 32'd50, "R2 run clear holds");
        wr(3'd2, 32'd70);
        wr(3'd0, RUN | (32'd1 << 24));
        @(negedge clk);
        rd(3'd4, 32'd50, "R5 no reload when bit clear");

        // R9 low-power gating sweep
        exp = 32'd50;
        for (int m = 0; m < 3; m++) begin
            logic [31:0] keep;
            keep = (m == 0) ? 32'h4_0000 : (m == 1) ? 32'h8_0000 : 32'h20_0000;
            modes = 3'(1 << m);
            tick(0);
            rd(3'd4, exp, "R9 frozen in low-power mode");
            wr(3'd0, RUN | keep | (32'd1 << 24));
            tick(0);
            exp = exp - 32'd1;
            rd(3'd4, exp, "R9 keep-running bit");
            wr(3'd0, RUN | (32'd1 << 24));
            modes = 3'b000;
        end

        // R10 soft reset
        wr(3'd3, 32'd7);
        wr(3'd0, RUN | OCIE | (32'd2 << 24));
        wr(3'd0, SRST | (32'd3 << 24) | 32'h8_0000 | RUN | RLDZ);
        rd(3'd0, 32'h0309_0000, "R10 busy cycle 1");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd(3'd0, 32'h0309_0000, "R10 busy cycles 2-4");
        end
        @(negedge clk);
        rd(3'd0, 32'h0308_0000, "R10 busy cleared, kept bits");
        rd(3'd2, 32'h0, "R10 load cleared");
        rd(3'd3, 32'h0, "R10 compare cleared");
        rd(3'd4, 32'h0, "R10 counter cleared");
        rd(3'd1, 32'h0, "R10 status cleared");
        wr(3'd0, SRST);
        wr(3'd2, 32'h33);
        repeat (5) @(negedge clk);
        rd(3'd2, 32'h0, "R10 write ignored while busy");

        summary();
        $finish;
    end
endmodule